// File: doc/BRIEF.md
# Status LED Pin Driver with Bicolor Error/Run Mode

This block turns logical on/off requests for a row of status LEDs into physical pin levels and output enables. The row holds a configurable number of link/activity LEDs (three by default), then one run/state LED, then one error LED. Each pin has its own polarity bit. The polarity field is loaded from strap inputs on the first clock after reset is released. A later register write can replace it.

The error LED pin is driven only when loaded configuration enables it. If configuration loading fails, the pin is forced on, but only when its polarity is active-low. A mode bit supports a two-colour LED that shares one package between run and error: the run output is then held at its inactive level while the error output is lit. Until the straps have been captured, every output enable stays low so that board pulls can be sampled. Blink patterns are generated upstream; all the inputs here are steady levels.

Top module: `status_led_drv`

## Requirements
- R1: All output enables are low while reset is asserted and stay low until the first rising clock edge after reset is released.
- R2: On the first rising clock edge after reset release, the polarity field is loaded from the strap inputs. Bit i governs pin i: the low bits are the link/activity LEDs, the next bit is the run LED, and the top bit is the error LED.
- R3: A polarity bit of 1 makes the pin active-high and 0 makes it active-low. A lit LED drives the active level, and an unlit LED drives the inverse of that level.
- R4: Once the straps are captured, a write strobe replaces the whole polarity field from the write data on that clock edge. The new value governs the pins from then on.
- R5: After capture, the output enables of all link/activity pins and of the run pin are high.
- R6: With the configuration error-enable bit set, the error pin's output enable is high after capture.
- R7: While the load-error flag is high, the error pin's output enable is forced high if the error polarity bit is 0. If that bit is 1, the flag has no effect.
- R8: When the error pin is not enabled (neither R6 nor R7 applies), its output enable is low, it drives its inactive level and it ignores its request.
- R9: When the bicolor mode bit is set and the error LED is lit (enabled and requested), the run pin drives its inactive level whatever the run request is.
- R10: When the bicolor mode bit is clear, or the error LED is not lit, the run pin follows its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| led_req | input | N_LINK+2 | Logical on requests, link LEDs low, then run, then error |
| strap_pol | input | N_LINK+2 | Polarity straps, sampled once after reset |
| pol_wr_en | input | 1 | Polarity register write strobe |
| pol_wr_data | input | N_LINK+2 | Polarity value to write |
| cfg_err_en | input | 1 | Error LED enable from loaded configuration |
| cfg_bicolor | input | 1 | State-run (bicolor) mode select |
| cfg_load_err | input | 1 | Configuration loading failed |
| led_pin | output | N_LINK+2 | Physical pin levels |
| led_oe | output | N_LINK+2 | Pin output enables |

## Verification
The bench checks the pins in the window between reset release and the first edge. A design that captures the straps inside reset, or enables the pins early, would drive against the strap pulls there. It sets both error polarities under a load error. A design that ignores polarity would force an active-high error pin on, and one that ignores the flag would leave an active-low pin dark. It also crosses bicolor mode with error lit, error requested but disabled, and mode clear. A design that forces the run pin off from the raw error request, rather than from the lit error output, would blank the run LED when the error pin is disabled. Finally, it uses asymmetric polarity patterns, so a bit-order swap or a run pin forced to 0 instead of its inactive level shows up in the pin levels.

// File: rtl/led_pkg.sv
package led_pkg;
  // Position of the run and error LEDs after N link LEDs
  function automatic int run_idx(input int n_link);
    return n_link;
  endfunction
  function automatic int err_idx(input int n_link);
    return n_link + 1;
  endfunction

  typedef struct packed {
    logic err_en;
    logic bicolor;
    logic load_err;
  } led_cfg_t;
endpackage

// File: rtl/led_pol_reg.sv
module led_pol_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strap,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pol,
  output logic         captured
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol      <= '0;
      captured <= 1'b0;
    end else if (!captured) begin
      pol      <= strap;
      captured <= 1'b1;
    end else if (wr_en) begin
      pol      <= wr_data;
    end
  end
endmodule

// File: rtl/led_err_gate.sv
module led_err_gate (
  input  logic captured,
  input  logic err_pol,
  input  logic cfg_err_en,
  input  logic load_err,
  output logic err_enable
);
  logic forced;
  // a failed load only forces the pin when it is wired active-low
  assign forced     = load_err & ~err_pol;
  assign err_enable = captured & (cfg_err_en | forced);
endmodule

// File: rtl/led_pin_drv.sv
module led_pin_drv (
  input  logic lit,
  input  logic pol,
  input  logic enable,
  output logic pin,
  output logic oe
);
  assign pin = lit ? pol : ~pol;
  assign oe  = enable;
endmodule

// File: rtl/status_led_drv.sv
module status_led_drv #(
  parameter int N_LINK = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINK+1:0] led_req,
  input  logic [N_LINK+1:0] strap_pol,
  input  logic              pol_wr_en,
  input  logic [N_LINK+1:0] pol_wr_data,
  input  logic              cfg_err_en,
  input  logic              cfg_bicolor,
  input  logic              cfg_load_err,
  output logic [N_LINK+1:0] led_pin,
  output logic [N_LINK+1:0] led_oe
);
  import led_pkg::*;

  localparam int NLED = N_LINK + 2;
  localparam int RUN  = run_idx(N_LINK);
  localparam int ERR  = err_idx(N_LINK);

  logic [NLED-1:0] pol_q;
  logic            captured;
  logic            err_enable;
  logic            err_lit;
  logic [NLED-1:0] lit;
  logic [NLED-1:0] en;
  led_cfg_t        cfg;

  assign cfg = '{err_en: cfg_err_en, bicolor: cfg_bicolor, load_err: cfg_load_err};

  led_pol_reg #(.W(NLED)) u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap    (strap_pol),
    .wr_en    (pol_wr_en),
    .wr_data  (pol_wr_data),
    .pol      (pol_q),
    .captured (captured)
  );

  led_err_gate u_errg (
    .captured   (captured),
    .err_pol    (pol_q[ERR]),
    .cfg_err_en (cfg.err_en),
    .load_err   (cfg.load_err),
    .err_enable (err_enable)
  );

  assign err_lit = err_enable & led_req[ERR];

  always_comb begin
    lit      = led_req;
    en       = {NLED{captured}};
    lit[ERR] = err_lit;
    en[ERR]  = err_enable;
    // bicolor package: run colour must be dark while error colour is lit
    lit[RUN] = led_req[RUN] & ~(cfg.bicolor & err_lit);
  end

  for (genvar i = 0; i < NLED; i++) begin : g_pin
    led_pin_drv u_drv (
      .lit    (lit[i]),
      .pol    (pol_q[i]),
      .enable (en[i]),
      .pin    (led_pin[i]),
      .oe     (led_oe[i])
    );
  end
endmodule

// File: rtl/status_led_drv_chk.sv
module status_led_drv_chk #(
  parameter int N_LINK = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_LINK+1:0] led_req,
  input logic [N_LINK+1:0] strap_pol,
  input logic              pol_wr_en,
  input logic [N_LINK+1:0] pol_wr_data,
  input logic              cfg_err_en,
  input logic              cfg_bicolor,
  input logic              cfg_load_err,
  input logic [N_LINK+1:0] led_pin,
  input logic [N_LINK+1:0] led_oe,
  input logic [N_LINK+1:0] pol_q,
  input logic              captured
);
  localparam int RUN = N_LINK;
  localparam int ERR = N_LINK + 1;

  AST_OE_LOW_PRE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |-> led_oe == '0); // R1
  AST_STRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(captured) |-> pol_q == $past(strap_pol)); // R2
  AST_POL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && pol_wr_en) |=> pol_q == $past(pol_wr_data)); // R4
  AST_LINK_RUN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    captured |-> led_oe[RUN:0] == '1); // R5
  AST_ERR_CFG_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && cfg_err_en) |-> led_oe[ERR]); // R6
  AST_ERR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && cfg_load_err && !pol_q[ERR]) |-> led_oe[ERR]); // R7
  AST_ERR_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_err_en && !(cfg_load_err && !pol_q[ERR]))
      |-> (!led_oe[ERR] && led_pin[ERR] == !pol_q[ERR])); // R8
  AST_RUN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bicolor && led_oe[ERR] && led_pin[ERR] == pol_q[ERR])
      |-> led_pin[RUN] == !pol_q[RUN]); // R9
endmodule

bind status_led_drv status_led_drv_chk #(.N_LINK(N_LINK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .led_req      (led_req),
  .strap_pol    (strap_pol),
  .pol_wr_en    (pol_wr_en),
  .pol_wr_data  (pol_wr_data),
  .cfg_err_en   (cfg_err_en),
  .cfg_bicolor  (cfg_bicolor),
  .cfg_load_err (cfg_load_err),
  .led_pin      (led_pin),
  .led_oe       (led_oe),
  .pol_q        (pol_q),
  .captured     (captured)
);

// File: tb/status_led_drv_bench.sv
module status_led_drv_bench;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] led_req = '0;
  logic [W-1:0] strap_pol = '0;
  logic         pol_wr_en = 1'b0;
  logic [W-1:0] pol_wr_data = '0;
  logic         cfg_err_en = 1'b0;
  logic         cfg_bicolor = 1'b0;
  logic         cfg_load_err = 1'b0;
  logic [W-1:0] led_pin;
  logic [W-1:0] led_oe;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] pol_exp = '0;
  bit done = 0;

  always #2 clk = ~clk;

  status_led_drv u_status_led_drv (
    .clk(clk), .rst_n(rst_n), .led_req(led_req), .strap_pol(strap_pol),
    .pol_wr_en(pol_wr_en), .pol_wr_data(pol_wr_data), .cfg_err_en(cfg_err_en),
    .cfg_bicolor(cfg_bicolor), .cfg_load_err(cfg_load_err),
    .led_pin(led_pin), .led_oe(led_oe)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // expected pins/enables from the requirement text
  function automatic logic [W-1:0] exp_oe();
    logic e;
    e = cfg_err_en | (cfg_load_err & ~pol_exp[4]);
    return {e, 4'b1111};
  endfunction

  function automatic logic [W-1:0] exp_pin();
    logic [W-1:0] on;
    logic e;
    e = cfg_err_en | (cfg_load_err & ~pol_exp[4]);
    on = led_req;
    on[4] = led_req[4] & e;
    if (cfg_bicolor && on[4]) on[3] = 1'b0;
    return (on & pol_exp) | (~on & ~pol_exp);
  endfunction

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " pin"}, led_pin, exp_pin());
    chk({tag, " oe"}, led_oe, exp_oe());
  endtask

  task automatic t_reset(input logic [W-1:0] strap);
    @(negedge clk);
    rst_n = 1'b0;
    strap_pol = strap;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", led_oe, '0);
    rst_n = 1'b1;
    #1;
    chk("R1 oe before first edge", led_oe, '0);
    settle();
    pol_exp = strap;
    chk("R5 oe after capture", led_oe & 5'b01111, 5'b01111);
    @(negedge clk);
    strap_pol = ~strap;
    settle();
    chk_all("R2 strap taken once");
  endtask

  task automatic t_polarity();
    @(negedge clk);
    cfg_err_en = 1'b1;
    led_req = 5'b11111;
    #1;
    chk_all("R3 R2 all lit");
    chk("R3 lit equals pol", led_pin, pol_exp);
    @(negedge clk);
    led_req = 5'b00000;
    #1;
    chk("R3 dark equals inverse pol", led_pin, ~pol_exp);
    @(negedge clk);
    led_req = 5'b01001;
    #1;
    chk_all("R3 mixed");
  endtask

  task automatic t_write(input logic [W-1:0] v);
    @(negedge clk);
    pol_wr_en = 1'b1;
    pol_wr_data = v;
    #1;
    chk_all("R4 before write edge");
    settle();
    pol_exp = v;
    @(negedge clk);
    pol_wr_en = 1'b0;
    pol_wr_data = ~v;
    #1;
    chk_all("R4 after write");
  endtask

  task automatic t_err_enable();
    @(negedge clk);
    cfg_bicolor = 1'b0;
    cfg_load_err = 1'b0;
    cfg_err_en = 1'b0;
    led_req = 5'b10000;
    #1;
    chk("R8 err oe low", {4'b0, led_oe[4]}, 5'b0);
    chk("R8 err inactive level", {4'b0, led_pin[4]}, {4'b0, ~pol_exp[4]});
    @(negedge clk);
    cfg_err_en = 1'b1;
    #1;
    chk("R6 err oe high", {4'b0, led_oe[4]}, 5'b1);
    chk_all("R6 err lit");
  endtask

  task automatic t_load_err();
    t_write(5'b00110);
    @(negedge clk);
    cfg_err_en = 1'b0;
    cfg_load_err = 1'b1;
    led_req = 5'b10000;
    #1;
    chk("R7 forced active-low", {4'b0, led_oe[4]}, 5'b1);
    chk_all("R7 forced pins");
    t_write(5'b10110);
    #1;
    chk("R7 active-high not forced", {4'b0, led_oe[4]}, 5'b0);
    chk_all("R7 R8 not forced pins");
    @(negedge clk);
    cfg_load_err = 1'b0;
  endtask

  task automatic t_bicolor();
    t_write(5'b01101);
    @(negedge clk);
    cfg_err_en = 1'b1;
    cfg_bicolor = 1'b1;
    led_req = 5'b11000;
    #1;
    chk("R9 run dark while err lit", {4'b0, led_pin[3]}, {4'b0, ~pol_exp[3]});
    chk_all("R9 pins");
    @(negedge clk);
    led_req = 5'b01000;
    #1;
    chk_all("R10 err off run follows");
    @(negedge clk);
    led_req = 5'b11000;
    cfg_err_en = 1'b0;
    #1;
    chk("R10 err disabled run lit", {4'b0, led_pin[3]}, {4'b0, pol_exp[3]});
    @(negedge clk);
    cfg_err_en = 1'b1;
    cfg_bicolor = 1'b0;
    #1;
    chk("R10 mode clear run lit", {4'b0, led_pin[3]}, {4'b0, pol_exp[3]});
    chk_all("R10 pins");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset(5'b10101);
    t_polarity();
    t_write(5'b01010);
    t_err_enable();
    t_load_err();
    t_bicolor();
    t_reset(5'b00011);
    t_polarity();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule